// File: doc/BRIEF.md
# Multifunction Pin Controller

This block owns three shared pads. Each pad can be a plain input, a driven output, or a host interrupt line driven open-drain or push-pull. Pad 0 can also put out a receive clock. That clock is either the recovered clock or the raw receive-clock input, chosen by a source bit. Configuration lives in a small write/read register file. Register 3 is read-only and returns the synchronized live level of every pad.

The same pads also carry external control into the chip. Pad 1 carries a start-of-frame level. Enabling it forces pad 1 to be an input. Its level can then gate receive-FIFO transfers and sets a maskable status bit for the embedded controller. Pad 2 carries a channel-busy level. A rising edge on pad 0 can start an analog-to-digital conversion. The internal sequencer can still start conversions as well.

All pad inputs pass through a two-flop synchronizer before any use. The block takes an asynchronous active-low reset. The release of that reset is synchronized inside the block.

Top module: `mfp_pins_top`

## Requirements

- R1: While reset is asserted, and right after it is released, no pad is driven. The values read back from registers 0 to 2 are zero, and `conv_start`, `sof_irq` and `ch_busy` are 0.
- R2: Register 3 bits [2:0] return the level of pads 2..0 two clock edges after the pad settles, in every pad mode. This includes pads the block drives itself.
- R3: Register 0 holds the output enables in bits [2:0] and the output values in bits [5:3]. When no higher-priority mode applies, pad i is driven with its value bit if its enable bit is set, and is left undriven if it is clear.
- R4: Register 0 bit 6 sets pad 0 to clock output. Register 0 bit 7 selects the source: 0 drives `rec_clk` and 1 drives `rx_clk_in`. Clock output overrides the plain output setting for pad 0.
- R5: A pad is in interrupt mode when register 1 bits [3:0] equal that pad's code. The codes are 10 for pad 0, 5 for pad 1 and 4 for pad 2. If register 1 bits [5:4] equal 1, the pad is open-drain: it drives 0 only while `host_irq` is high. Any other value makes it push-pull, driving `host_irq`. Interrupt mode overrides clock and plain output.
- R6: Register 2 bit 0 (start-of-frame enable) leaves pad 1 undriven, whatever every other setting is.
- R7: Register 2 bit 1 is the busy enable and bit 2 is the antenna qualifier. The external gate is active when the start-of-frame enable and the busy enable are both set, and either the qualifier is 0 or `ant_sel_done` is 1. While the gate is active, `rx_xfer_en` equals `rx_sm_en` AND the pad 1 level. Otherwise `rx_xfer_en` equals `rx_sm_en`.
- R8: Register 3 bit 3 is a status bit. Each clock it is loaded with the synchronized pad 1 level if the start-of-frame enable is set, and with 0 otherwise. `sof_irq` equals that bit AND NOT register 2 bit 4 (the mask).
- R9: `ch_busy` equals the synchronized pad 2 level while the busy enable is set, and is 0 otherwise.
- R10: With register 2 bit 3 set, a rising edge of the synchronized pad 0 level makes `conv_start` high for exactly one cycle. This works in any pad 0 mode. A falling edge, or a rising edge with the bit clear, gives no pulse. `seq_conv_start` is ORed into `conv_start` in the same cycle.
- R11: Registers 0, 1 and 2 read back what was last written. Bits of registers 1 and 2 that hold no field read as 0.

## Ports

| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data (combinational) |
| pad_in | input | 3 | Pad input levels |
| pad_out | output | 3 | Pad output values |
| pad_oe | output | 3 | Pad output enables |
| rec_clk | input | 1 | Recovered receive clock |
| rx_clk_in | input | 1 | Raw receive-clock input |
| host_irq | input | 1 | Host interrupt request, active high |
| rx_sm_en | input | 1 | Firmware receive state-machine enable |
| ant_sel_done | input | 1 | Antenna selection has been made |
| seq_conv_start | input | 1 | Conversion start from the internal sequencer |
| rx_xfer_en | output | 1 | Receive-FIFO transfer enable |
| ch_busy | output | 1 | Channel-busy status |
| sof_irq | output | 1 | Start-of-frame interrupt to the embedded controller |
| conv_start | output | 1 | Single-cycle conversion start |

## Verification

Two conversion starts can fall in the same cycle: one from the internal sequencer and one from the synchronized pad 0 edge. The bench raises pad 0, counts two edges, and pulses `seq_conv_start` in exactly the cycle the synchronized edge arrives. The result must be one high cycle on `conv_start`, with no second pulse one cycle later. The pad drive is swept over every interrupt select code and interrupt type, with and without the start-of-frame override. Expected drive is worked out from the priority order in the requirements.

// File: rtl/mfp_pkg.sv
package mfp_pkg;
  localparam int NPIN     = 3;
  localparam int IRQW     = 4;
  localparam int TYPW     = 2;
  localparam int PIN_CLK  = 0;
  localparam int PIN_SOF  = 1;
  localparam int PIN_BUSY = 2;
  localparam logic [TYPW-1:0] TYPE_OPEN_DRAIN = 2'd1;

  typedef enum logic [2:0] {
    PM_IN,
    PM_OUT,
    PM_IRQ_OD,
    PM_IRQ_PP,
    PM_CLK
  } pin_mode_e;

  typedef struct packed {
    logic [NPIN-1:0] drv_en;
    logic [NPIN-1:0] drv_val;
    logic            clk_func;
    logic            clk_src;
    logic [IRQW-1:0] irq_sel;
    logic [TYPW-1:0] irq_type;
    logic            sof_en;
    logic            busy_en;
    logic            ant_qual;
    logic            conv_ext_en;
    logic            sof_mask;
  } cfg_t;

  // interrupt select code that routes the host interrupt to a pad
  function automatic logic [IRQW-1:0] irq_code(input int idx);
    case (idx)
      0:       return 4'd10;
      1:       return 4'd5;
      default: return 4'd4;
    endcase
  endfunction
endpackage

// File: rtl/mfp_sync.sv
module mfp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = d;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/mfp_regs.sv
module mfp_regs
  import mfp_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] stat_word,
  output logic [DW-1:0] rdata,
  output cfg_t          cfg
);
  localparam logic [AW-1:0] A_PIN = AW'(0);
  localparam logic [AW-1:0] A_IRQ = AW'(1);
  localparam logic [AW-1:0] A_EXT = AW'(2);

  cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    case (addr)
      A_PIN: begin
        cfg_d.drv_en   = wdata[NPIN-1:0];
        cfg_d.drv_val  = wdata[2*NPIN-1:NPIN];
        cfg_d.clk_func = wdata[2*NPIN];
        cfg_d.clk_src  = wdata[2*NPIN+1];
      end
      A_IRQ: begin
        cfg_d.irq_sel  = wdata[IRQW-1:0];
        cfg_d.irq_type = wdata[IRQW+TYPW-1:IRQW];
      end
      A_EXT: begin
        cfg_d.sof_en      = wdata[0];
        cfg_d.busy_en     = wdata[1];
        cfg_d.ant_qual    = wdata[2];
        cfg_d.conv_ext_en = wdata[3];
        cfg_d.sof_mask    = wdata[4];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg_q <= '0;
    else if (wr_en) cfg_q <= cfg_d;
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_PIN: rdata[2*NPIN+1:0] = {cfg_q.clk_src, cfg_q.clk_func, cfg_q.drv_val, cfg_q.drv_en};
      A_IRQ: rdata[IRQW+TYPW-1:0] = {cfg_q.irq_type, cfg_q.irq_sel};
      A_EXT: rdata[4:0] = {cfg_q.sof_mask, cfg_q.conv_ext_en, cfg_q.ant_qual,
                           cfg_q.busy_en, cfg_q.sof_en};
      default: rdata = stat_word;
    endcase
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/mfp_pad_ctl.sv
module mfp_pad_ctl
  import mfp_pkg::*;
(
  input  logic [NPIN-1:0] drv_en,
  input  logic [NPIN-1:0] drv_val,
  input  logic            clk_func,
  input  logic            clk_drive,
  input  logic [IRQW-1:0] irq_sel,
  input  logic [TYPW-1:0] irq_type,
  input  logic            sof_en,
  input  logic            host_irq,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe
);
  genvar i;
  generate
    for (i = 0; i < NPIN; i++) begin : g_pin
      localparam bit              CLK_CAPABLE = (i == PIN_CLK);
      localparam bit              SOF_PIN     = (i == PIN_SOF);
      localparam logic [IRQW-1:0] MY_CODE     = irq_code(i);

      pin_mode_e mode;
      logic      oe_b, out_b;

      // priority: override > interrupt > clock > plain output > input
      always_comb begin
        if (SOF_PIN && sof_en)
          mode = PM_IN;
        else if (irq_sel == MY_CODE)
          mode = (irq_type == TYPE_OPEN_DRAIN) ? PM_IRQ_OD : PM_IRQ_PP;
        else if (CLK_CAPABLE && clk_func)
          mode = PM_CLK;
        else if (drv_en[i])
          mode = PM_OUT;
        else
          mode = PM_IN;
      end

      always_comb begin
        case (mode)
          PM_OUT:    begin oe_b = 1'b1;     out_b = drv_val[i]; end
          PM_IRQ_OD: begin oe_b = host_irq; out_b = 1'b0;       end
          PM_IRQ_PP: begin oe_b = 1'b1;     out_b = host_irq;   end
          PM_CLK:    begin oe_b = 1'b1;     out_b = clk_drive;  end
          default:   begin oe_b = 1'b0;     out_b = 1'b0;       end
        endcase
      end

      assign pad_oe[i]  = oe_b;
      assign pad_out[i] = out_b;
    end
  endgenerate
endmodule

// File: rtl/mfp_ext_ctl.sv
module mfp_ext_ctl
  import mfp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] lvl,
  input  logic            sof_en,
  input  logic            busy_en,
  input  logic            ant_qual,
  input  logic            conv_ext_en,
  input  logic            sof_mask,
  input  logic            rx_sm_en,
  input  logic            ant_sel_done,
  input  logic            seq_conv_start,
  output logic            rx_xfer_en,
  output logic            ch_busy,
  output logic            sof_stat,
  output logic            sof_irq,
  output logic            conv_start
);
  logic ext_gate_on;
  logic clk_prev_q, clk_prev_d;
  logic stat_q, stat_d;

  always_comb begin
    ext_gate_on = sof_en & busy_en & (~ant_qual | ant_sel_done);
    rx_xfer_en  = ext_gate_on ? (rx_sm_en & lvl[PIN_SOF]) : rx_sm_en;
    ch_busy     = busy_en & lvl[PIN_BUSY];
    clk_prev_d  = lvl[PIN_CLK];
    stat_d      = sof_en & lvl[PIN_SOF];
    conv_start  = seq_conv_start | (conv_ext_en & lvl[PIN_CLK] & ~clk_prev_q);
    sof_irq     = stat_q & ~sof_mask;
    sof_stat    = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_prev_q <= 1'b0;
      stat_q     <= 1'b0;
    end else begin
      clk_prev_q <= clk_prev_d;
      stat_q     <= stat_d;
    end
  end
endmodule

// File: rtl/mfp_pins_top.sv
module mfp_pins_top
  import mfp_pkg::*;
#(
  parameter int AW          = 2,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [AW-1:0]   cfg_addr,
  input  logic [DW-1:0]   cfg_wdata,
  output logic [DW-1:0]   cfg_rdata,
  input  logic [NPIN-1:0] pad_in,
  output logic [NPIN-1:0] pad_out,
  output logic [NPIN-1:0] pad_oe,
  input  logic            rec_clk,
  input  logic            rx_clk_in,
  input  logic            host_irq,
  input  logic            rx_sm_en,
  input  logic            ant_sel_done,
  input  logic            seq_conv_start,
  output logic            rx_xfer_en,
  output logic            ch_busy,
  output logic            sof_irq,
  output logic            conv_start
);
  localparam int STAT_PAD = DW - NPIN - 1;

  logic            rst_ni;
  logic [NPIN-1:0] lvl;
  logic            sof_stat;
  logic            clk_drive;
  logic [DW-1:0]   stat_word;
  cfg_t            cfg;

  // reset: asserted at once, released after SYNC_STAGES edges
  mfp_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_ni)
  );

  mfp_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_pad_sync (
    .clk(clk), .rst_n(rst_ni), .d(pad_in), .q(lvl)
  );

  assign stat_word = {{STAT_PAD{1'b0}}, sof_stat, lvl};

  mfp_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_ni), .wr_en(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .stat_word(stat_word), .rdata(cfg_rdata), .cfg(cfg)
  );

  assign clk_drive = cfg.clk_src ? rx_clk_in : rec_clk;

  mfp_pad_ctl u_pad (
    .drv_en(cfg.drv_en), .drv_val(cfg.drv_val), .clk_func(cfg.clk_func),
    .clk_drive(clk_drive), .irq_sel(cfg.irq_sel), .irq_type(cfg.irq_type),
    .sof_en(cfg.sof_en), .host_irq(host_irq), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  mfp_ext_ctl u_ext (
    .clk(clk), .rst_n(rst_ni), .lvl(lvl),
    .sof_en(cfg.sof_en), .busy_en(cfg.busy_en), .ant_qual(cfg.ant_qual),
    .conv_ext_en(cfg.conv_ext_en), .sof_mask(cfg.sof_mask),
    .rx_sm_en(rx_sm_en), .ant_sel_done(ant_sel_done),
    .seq_conv_start(seq_conv_start), .rx_xfer_en(rx_xfer_en),
    .ch_busy(ch_busy), .sof_stat(sof_stat), .sof_irq(sof_irq),
    .conv_start(conv_start)
  );
endmodule

// File: rtl/mfp_pins_chk.sv
module mfp_pins_chk
  import mfp_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_we,
  input logic [AW-1:0]   cfg_addr,
  input logic [DW-1:0]   cfg_wdata,
  input logic            sof_pin_in,
  input logic            busy_pin_in,
  input logic [NPIN-1:0] pad_oe,
  input logic            rx_sm_en,
  input logic            seq_conv_start,
  input logic            rx_xfer_en,
  input logic            ch_busy,
  input logic            sof_irq,
  input logic            conv_start
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (pad_oe == '0 && !sof_irq && !conv_start));

  // R6
  sof_force_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == AW'(2) && cfg_wdata[0]) |=> !pad_oe[PIN_SOF]);

  // R7
  xfer_needs_fw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_xfer_en |-> rx_sm_en);

  // R8 (two synchronizer stages plus the status flop)
  sof_irq_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_irq |-> $past(sof_pin_in, 3));

  // R9 (two synchronizer stages)
  busy_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_busy |-> $past(busy_pin_in, 2));

  // R10
  conv_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_start && !seq_conv_start) |=> (!conv_start || seq_conv_start));
endmodule

bind mfp_pins_top mfp_pins_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .sof_pin_in(pad_in[mfp_pkg::PIN_SOF]),
  .busy_pin_in(pad_in[mfp_pkg::PIN_BUSY]), .pad_oe(pad_oe),
  .rx_sm_en(rx_sm_en), .seq_conv_start(seq_conv_start),
  .rx_xfer_en(rx_xfer_en), .ch_busy(ch_busy), .sof_irq(sof_irq),
  .conv_start(conv_start)
);

// File: tb/test_mfp_pins_top.sv
module test_mfp_pins_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_we;
  logic [1:0] cfg_addr;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic [2:0] pad_in, pad_out, pad_oe;
  logic [2:0] ext_lvl;
  logic       rec_clk, rx_clk_in, host_irq, rx_sm_en, ant_sel_done, seq_conv_start;
  logic       rx_xfer_en, ch_busy, sof_irq, conv_start;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // board model: a driven pad follows the block, otherwise the outside level
  for (genvar g = 0; g < 3; g++) begin : g_board
    assign pad_in[g] = pad_oe[g] ? pad_out[g] : ext_lvl[g];
  end

  mfp_pins_top i_mfp_pins_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .rec_clk(rec_clk), .rx_clk_in(rx_clk_in),
    .host_irq(host_irq), .rx_sm_en(rx_sm_en), .ant_sel_done(ant_sel_done),
    .seq_conv_start(seq_conv_start), .rx_xfer_en(rx_xfer_en), .ch_busy(ch_busy),
    .sof_irq(sof_irq), .conv_start(conv_start)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_addr = 2'd3;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    cfg_addr = a; #1; d = cfg_rdata; cfg_addr = 2'd3;
  endtask

  // expected {oe, out} of pad i, from the priority order in R3..R6
  function automatic logic [1:0] exp_drive(input int i, input logic [7:0] r0,
      input logic [7:0] r1, input logic sofe, input logic hirq,
      input logic rclk, input logic rxin);
    logic [3:0] code;
    code = (i == 0) ? 4'd10 : (i == 1) ? 4'd5 : 4'd4;
    if (i == 1 && sofe) return 2'b00;
    if (r1[3:0] == code) return (r1[5:4] == 2'd1) ? {hirq, 1'b0} : {1'b1, hirq};
    if (i == 0 && r0[6]) return {1'b1, r0[7] ? rxin : rclk};
    if (r0[i]) return {1'b1, r0[3+i]};
    return 2'b00;
  endfunction

  function automatic string tag_of(input int i, input logic [7:0] r0,
                                   input logic [7:0] r1, input logic sofe);
    logic [3:0] code;
    code = (i == 0) ? 4'd10 : (i == 1) ? 4'd5 : 4'd4;
    if (i == 1 && sofe) return "R6";
    if (r1[3:0] == code) return "R5";
    if (i == 0 && r0[6]) return "R4";
    return "R3";
  endfunction

  task automatic check_pads(input logic [7:0] r0, input logic [7:0] r1, input logic sofe);
    for (int i = 0; i < 3; i++) begin
      logic [1:0] e, a;
      e = exp_drive(i, r0, r1, sofe, host_irq, rec_clk, rx_clk_in);
      a = {pad_oe[i], pad_oe[i] & pad_out[i]};
      chk(tag_of(i, r0, r1, sofe), $sformatf("pad%0d drive", i), {30'd0, a}, {30'd0, e});
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b1; cfg_we = 1'b0; cfg_addr = 2'd3; cfg_wdata = '0; ext_lvl = '0;
    rec_clk = 0; rx_clk_in = 0; host_irq = 0; rx_sm_en = 0; ant_sel_done = 0;
    seq_conv_start = 0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1", "oe in reset", {29'd0, pad_oe}, 32'd0);
    chk("R1", "conv_start in reset", {31'd0, conv_start}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "oe after reset", {29'd0, pad_oe}, 32'd0);
    chk("R1", "sof_irq after reset", {31'd0, sof_irq}, 32'd0);
    chk("R1", "ch_busy after reset", {31'd0, ch_busy}, 32'd0);
    for (int a = 0; a < 3; a++) begin
      rd(a[1:0], d);
      chk("R1", $sformatf("reg%0d after reset", a), {24'd0, d}, 32'd0);
    end

    // R11 readback
    for (int p = 0; p < 256; p += 37) begin
      wr(2'd0, p[7:0]); wr(2'd1, ~p[7:0]); wr(2'd2, p[7:0] ^ 8'h5a);
      rd(2'd0, d); chk("R11", "reg0", {24'd0, d}, {24'd0, p[7:0]});
      rd(2'd1, d); chk("R11", "reg1", {24'd0, d}, {24'd0, ~p[7:0] & 8'h3f});
      rd(2'd2, d); chk("R11", "reg2", {24'd0, d}, {24'd0, (p[7:0] ^ 8'h5a) & 8'h1f});
    end
    wr(2'd1, 8'h00); wr(2'd2, 8'h00);

    // R3/R4 sweep: every enable, value, clock function, source and clock level
    for (int v = 0; v < 256; v++) begin
      wr(2'd0, v[7:0]);
      for (int c = 0; c < 4; c++) begin
        rec_clk = c[0]; rx_clk_in = c[1]; #1;
        check_pads(v[7:0], 8'h00, 1'b0);
      end
    end

    // R5/R6 sweep: every select code, type, request level and override
    for (int s = 0; s < 16; s++)
      for (int t = 0; t < 4; t++)
        for (int so = 0; so < 2; so++) begin
          wr(2'd0, 8'h6f);           // all enabled, vals 101, clock func, src rec_clk
          wr(2'd1, {2'b00, t[1:0], s[3:0]});
          wr(2'd2, {7'd0, so[0]});
          for (int h = 0; h < 2; h++) begin
            host_irq = h[0]; rec_clk = ~rec_clk; #1;
            check_pads(8'h6f, {2'b00, t[1:0], s[3:0]}, so[0]);
          end
        end
    host_irq = 0;

    // R2 live level in four modes
    for (int m = 0; m < 4; m++) begin
      logic [7:0] r0, r1;
      logic       so;
      r0 = (m == 1 || m == 2) ? ((m == 1) ? 8'h2f : 8'h17) : 8'h00;
      r1 = (m == 3) ? 8'h24 : 8'h00;   // pad 2 push-pull interrupt
      so = (m == 2);
      wr(2'd0, r0); wr(2'd1, r1); wr(2'd2, {7'd0, so});
      host_irq = (m == 3);
      for (int e = 0; e < 8; e++) begin
        logic [2:0] exp_l;
        ext_lvl = e[2:0];
        for (int i = 0; i < 3; i++) begin
          logic [1:0] dr;
          dr = exp_drive(i, r0, r1, so, host_irq, rec_clk, rx_clk_in);
          exp_l[i] = dr[1] ? dr[0] : ext_lvl[i];
        end
        repeat (2) @(negedge clk);
        rd(2'd3, d);
        chk("R2", $sformatf("live level mode%0d", m), {29'd0, d[2:0]}, {29'd0, exp_l});
      end
    end
    host_irq = 0;
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);

    // R7/R8/R9 sweep over gating inputs and pad levels
    for (int v = 0; v < 256; v++) begin
      logic sofe, busye, antq, msk, antd, rxsm, sl, bl, gate, st;
      sofe = v[0]; busye = v[1]; antq = v[2]; msk = v[3];
      antd = v[4]; rxsm = v[5]; sl = v[6]; bl = v[7];
      wr(2'd2, {3'd0, msk, 1'b0, antq, busye, sofe});
      ext_lvl = {bl, sl, 1'b0}; ant_sel_done = antd; rx_sm_en = rxsm;
      repeat (2) @(negedge clk);
      gate = sofe & busye & (~antq | antd);
      chk("R7", "rx_xfer_en", {31'd0, rx_xfer_en}, {31'd0, gate ? (rxsm & sl) : rxsm});
      chk("R9", "ch_busy", {31'd0, ch_busy}, {31'd0, busye & bl});
      @(negedge clk);
      st = sofe & sl;
      rd(2'd3, d);
      chk("R8", "status bit", {31'd0, d[3]}, {31'd0, st});
      chk("R8", "sof_irq", {31'd0, sof_irq}, {31'd0, st & ~msk});
    end
    rx_sm_en = 0; ant_sel_done = 0; ext_lvl = '0;

    // R10 conversion start
    wr(2'd2, 8'h08);
    repeat (3) @(negedge clk);
    chk("R10", "idle", {31'd0, conv_start}, 32'd0);
    ext_lvl[0] = 1'b1;
    @(negedge clk); chk("R10", "edge +1", {31'd0, conv_start}, 32'd0);
    @(negedge clk); chk("R10", "edge +2", {31'd0, conv_start}, 32'd1);
    @(negedge clk); chk("R10", "edge +3", {31'd0, conv_start}, 32'd0);
    ext_lvl[0] = 1'b0;
    begin
      int hits = 0;
      for (int k = 0; k < 4; k++) begin @(negedge clk); hits += conv_start; end
      chk("R10", "falling edge pulses", hits, 32'd0);
    end
    seq_conv_start = 1'b1; #1;
    chk("R10", "sequencer start", {31'd0, conv_start}, 32'd1);
    @(negedge clk); seq_conv_start = 1'b0; #1;
    chk("R10", "sequencer start ends", {31'd0, conv_start}, 32'd0);
    // coinciding sequencer start and pad edge
    ext_lvl[0] = 1'b1;
    begin
      int hits = 0;
      @(negedge clk); hits += conv_start;
      @(negedge clk); seq_conv_start = 1'b1; #1; hits += conv_start;
      @(negedge clk); seq_conv_start = 1'b0; #1; hits += conv_start;
      @(negedge clk); hits += conv_start;
      chk("R10", "coinciding starts", hits, 32'd1);
    end
    ext_lvl[0] = 1'b0; repeat (3) @(negedge clk);
    wr(2'd2, 8'h00);
    ext_lvl[0] = 1'b1;
    begin
      int hits = 0;
      for (int k = 0; k < 4; k++) begin @(negedge clk); hits += conv_start; end
      chk("R10", "edge while disabled", hits, 32'd0);
    end
    // edge on a pad driven as clock output
    ext_lvl[0] = 1'b0; rec_clk = 1'b0;
    wr(2'd2, 8'h08); wr(2'd0, 8'h40);
    repeat (3) @(negedge clk);
    rec_clk = 1'b1;
    repeat (2) @(negedge clk);
    chk("R10", "edge from clock output", {31'd0, conv_start}, 32'd1);
    @(negedge clk);
    chk("R10", "clock edge pulse ends", {31'd0, conv_start}, 32'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule